// File: doc/BRIEF.md
# Two-Counter Bit Stack

This block keeps a last-in, first-out stack of single bits inside one unsigned counter. The stack is read as a binary number whose least significant bit is the top entry. A second counter of the same width serves as scratch space. The only operations either counter can perform are a step up by one, a step down by one, a clear, and a zero test. Pushes and pops are therefore long loops run by a small state machine. No shifter, adder or comparator ever operates on a counter value.

A push of bit b turns the stored value v into 2v+b. The machine drains the primary counter one unit at a time and adds two units to the scratch counter for each unit removed. It adds one more unit when b is 1. It then moves the scratch value back into the primary counter one unit at a time. A pop turns v into v/2. The machine takes two units from the primary counter for each unit it gives to the scratch counter. The popped bit is the remainder. The state machine knows the remainder from which of its two drain states saw the primary counter reach zero. The result is then moved back in the same way as for a push.

A requester raises `req_valid` with `req_pop` and `req_bit` while `ready` is high. It then waits for the one-cycle `done` pulse. Latency grows with the stored value: roughly seven cycles per unit for a push and two and a half per unit for a pop.

Top module: `twocnt_bit_stack`

## Requirements
- R1: Bits come back in last-in, first-out order. The top of the stack is the least significant bit of the primary counter value.
- R2: A push of bit b onto stored value v leaves the value 2v+b. Its `done` pulse appears 7v+3b+3 cycles after the clock edge that accepted the request.
- R3: A pop of a nonzero stored value v = 2q+r leaves q and presents r on `pop_bit`. Its `done` pulse appears 5q+r+3 cycles after the accepting edge.
- R4: In any cycle at most one of the two counters changes. The primary counter changes only by plus or minus one. The scratch counter changes only by plus or minus one or by clearing to zero.
- R5: `done` is high for exactly one cycle, and `ready` is high in the cycle after it. `ready` is high only when no operation is in progress.
- R6: A request raised while `ready` is low is ignored. The operation in progress keeps its latency and result.
- R7: A pop when the stored value is zero completes in the cycle after the accepting edge. It returns `pop_bit` = 0 and leaves the stack empty.
- R8: A push when the most significant bit of the primary counter is set is refused. It completes in the cycle after the accepting edge with `overflow` = 1 and leaves the stored value unchanged.
- R9: `overflow` holds until the next accepted request that is not refused. That request clears it.
- R10: After reset, `ready` = 1, `done` = 0, `empty` = 1, `overflow` = 0 and `pop_bit` = 0.
- R11: `empty` is high exactly when `ready` is high and the stored value is zero. Pushing 0 onto an empty stack leaves it empty.
- R12: The scratch counter holds zero whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while `ready` is high |
| req_pop | input | 1 | 1 = pop, 0 = push |
| req_bit | input | 1 | Bit to push |
| ready | output | 1 | Idle and able to take a request |
| done | output | 1 | One-cycle pulse when an operation finishes |
| pop_bit | output | 1 | Bit returned by the latest pop |
| empty | output | 1 | Idle with a stored value of zero |
| overflow | output | 1 | Latest push was refused for lack of range |

## Verification
Several rules are checked on every clock cycle by properties:
- only one counter moves per cycle, in single steps or a scratch clear;
- `done` lasts one cycle and returns to idle;
- the scratch counter is zero whenever the block is idle;
- an operation already running is never cut short;
- a refused push leaves the primary value untouched.

Other behaviours need whole sequences and are shown only by the bench scenarios:
- exact latencies as a function of the stored value;
- the LIFO order of returned bits;
- the parity-derived pop bit;
- loss of leading zeros on an empty stack;
- rejection of stray requests while busy;
- the overflow set and clear sequence.

// File: rtl/tcbs_pkg.sv
package tcbs_pkg;

    // Stepping commands a unit counter understands
    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_UP   = 2'd1,
        CNT_DOWN = 2'd2,
        CNT_ZERO = 2'd3
    } cnt_op_e;

    // Sequencer states
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_DBL_TAKE,
        ST_DBL_ADD_A,
        ST_DBL_ADD_B,
        ST_APPEND,
        ST_HLV_TAKE_A,
        ST_HLV_TAKE_B,
        ST_HLV_GIVE,
        ST_MOVE_TAKE,
        ST_MOVE_GIVE,
        ST_FINISH
    } seq_state_e;

    localparam int NUM_CNT = 2;
    localparam int PRI_IDX = 0;
    localparam int SCR_IDX = 1;

    typedef struct packed {
        logic pop;
        logic bit_in;
    } stack_req_t;

    typedef struct packed {
        cnt_op_e pri;
        cnt_op_e scr;
    } cnt_cmd_t;

    localparam cnt_cmd_t CMD_IDLE = '{pri: CNT_HOLD, scr: CNT_HOLD};

    // Build a command that moves exactly one counter
    function automatic cnt_cmd_t single_step(input logic on_scratch, input cnt_op_e op);
        cnt_cmd_t c;
        c.pri = on_scratch ? CNT_HOLD : op;
        c.scr = on_scratch ? op : CNT_HOLD;
        return c;
    endfunction

endpackage

// File: rtl/tcbs_step_counter.sv
module tcbs_step_counter
    import tcbs_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_op_e          op,
    output logic [WIDTH-1:0] value,
    output logic             is_zero
);

    localparam logic [WIDTH-1:0] ONE     = WIDTH'(1);
    localparam logic [WIDTH-1:0] ALL_SET = '1;

    logic [WIDTH-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            unique case (op)
                CNT_UP:   if (count_q != ALL_SET) count_q <= count_q + ONE;
                CNT_DOWN: if (count_q != '0)      count_q <= count_q - ONE;
                CNT_ZERO: count_q <= '0;
                default:  count_q <= count_q;
            endcase
        end
    end

    assign value   = count_q;
    assign is_zero = (count_q == '0);

endmodule

// File: rtl/tcbs_sequencer.sv
module tcbs_sequencer
    import tcbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  stack_req_t req,
    input  logic       pri_zero,
    input  logic       pri_full_top,
    input  logic       scr_zero,
    output cnt_cmd_t   cmd,
    output logic       ready,
    output logic       done,
    output logic       pop_bit,
    output logic       overflow
);

    seq_state_e state_q, state_d;
    stack_req_t op_q;
    logic       pop_bit_q;
    logic       ovf_q;

    logic accept;
    logic refuse_push;
    logic empty_pop;

    assign accept      = (state_q == ST_IDLE) && req_valid;
    assign refuse_push = accept && !req.pop && pri_full_top;
    assign empty_pop   = accept && req.pop && pri_zero;

    // Next state and counter command
    always_comb begin
        state_d = state_q;
        cmd     = CMD_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = (refuse_push || empty_pop) ? ST_FINISH : ST_CLEAR;
                end
            end
            ST_CLEAR: begin
                cmd     = single_step(1'b1, CNT_ZERO);
                state_d = op_q.pop ? ST_HLV_TAKE_A : ST_DBL_TAKE;
            end
            // Doubling: one unit out of primary, two into scratch
            ST_DBL_TAKE: begin
                if (pri_zero) begin
                    state_d = op_q.bit_in ? ST_APPEND : ST_MOVE_TAKE;
                end else begin
                    cmd     = single_step(1'b0, CNT_DOWN);
                    state_d = ST_DBL_ADD_A;
                end
            end
            ST_DBL_ADD_A: begin
                cmd     = single_step(1'b1, CNT_UP);
                state_d = ST_DBL_ADD_B;
            end
            ST_DBL_ADD_B: begin
                cmd     = single_step(1'b1, CNT_UP);
                state_d = ST_DBL_TAKE;
            end
            ST_APPEND: begin
                cmd     = single_step(1'b1, CNT_UP);
                state_d = ST_MOVE_TAKE;
            end
            // Halving: two units out of primary, one into scratch.
            // Which take state sees zero encodes the parity.
            ST_HLV_TAKE_A: begin
                if (pri_zero) begin
                    state_d = ST_MOVE_TAKE;
                end else begin
                    cmd     = single_step(1'b0, CNT_DOWN);
                    state_d = ST_HLV_TAKE_B;
                end
            end
            ST_HLV_TAKE_B: begin
                if (pri_zero) begin
                    state_d = ST_MOVE_TAKE;
                end else begin
                    cmd     = single_step(1'b0, CNT_DOWN);
                    state_d = ST_HLV_GIVE;
                end
            end
            ST_HLV_GIVE: begin
                cmd     = single_step(1'b1, CNT_UP);
                state_d = ST_HLV_TAKE_A;
            end
            // Transfer scratch back into primary
            ST_MOVE_TAKE: begin
                if (scr_zero) begin
                    state_d = ST_FINISH;
                end else begin
                    cmd     = single_step(1'b1, CNT_DOWN);
                    state_d = ST_MOVE_GIVE;
                end
            end
            ST_MOVE_GIVE: begin
                cmd     = single_step(1'b0, CNT_UP);
                state_d = ST_MOVE_TAKE;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            op_q      <= '0;
            pop_bit_q <= 1'b0;
            ovf_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q  <= req;
                ovf_q <= refuse_push;
            end
            if (empty_pop) begin
                pop_bit_q <= 1'b0;
            end else if (state_q == ST_HLV_TAKE_A && pri_zero) begin
                pop_bit_q <= 1'b0;
            end else if (state_q == ST_HLV_TAKE_B && pri_zero) begin
                pop_bit_q <= 1'b1;
            end
        end
    end

    assign ready    = (state_q == ST_IDLE);
    assign done     = (state_q == ST_FINISH);
    assign pop_bit  = pop_bit_q;
    assign overflow = ovf_q;

endmodule

// File: rtl/twocnt_bit_stack.sv
module twocnt_bit_stack
    import tcbs_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic req_pop,
    input  logic req_bit,
    output logic ready,
    output logic done,
    output logic pop_bit,
    output logic empty,
    output logic overflow
);

    localparam int TOP_BIT = CNT_W - 1;

    stack_req_t       req;
    cnt_cmd_t         cmd;
    cnt_op_e          cnt_op   [NUM_CNT];
    logic [CNT_W-1:0] cnt_val  [NUM_CNT];
    logic             cnt_zero [NUM_CNT];
    logic [CNT_W-1:0] pri_q;
    logic [CNT_W-1:0] scr_q;

    assign req.pop    = req_pop;
    assign req.bit_in = req_bit;

    assign cnt_op[PRI_IDX] = cmd.pri;
    assign cnt_op[SCR_IDX] = cmd.scr;

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        tcbs_step_counter #(
            .WIDTH (CNT_W)
        ) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .op      (cnt_op[i]),
            .value   (cnt_val[i]),
            .is_zero (cnt_zero[i])
        );
    end

    assign pri_q = cnt_val[PRI_IDX];
    assign scr_q = cnt_val[SCR_IDX];

    tcbs_sequencer u_seq (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req          (req),
        .pri_zero     (cnt_zero[PRI_IDX]),
        .pri_full_top (pri_q[TOP_BIT]),
        .scr_zero     (cnt_zero[SCR_IDX]),
        .cmd          (cmd),
        .ready        (ready),
        .done         (done),
        .pop_bit      (pop_bit),
        .overflow     (overflow)
    );

    assign empty = ready && cnt_zero[PRI_IDX];

endmodule

// File: rtl/tcbs_checker.sv
module tcbs_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] pri,
    input logic [CNT_W-1:0] scr,
    input logic             ready,
    input logic             done,
    input logic             empty,
    input logic             overflow
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    AST_SINGLE_MOVER: assert property (@(posedge clk) disable iff (rst)
        !((pri != $past(pri)) && (scr != $past(scr)))); // R4

    AST_PRI_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
        (pri != $past(pri)) |-> ((pri == $past(pri) + ONE) || (pri == $past(pri) - ONE))); // R4

    AST_SCR_STEP_OR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (scr != $past(scr)) |-> ((scr == $past(scr) + ONE) || (scr == $past(scr) - ONE) || (scr == '0))); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R5

    AST_DONE_TO_READY: assert property (@(posedge clk) disable iff (rst)
        done |=> ready); // R5

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!ready && !done) |=> !ready); // R6

    AST_OVF_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> (pri == $past(pri))); // R8

    AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (rst)
        empty |-> (ready && pri == '0)); // R11

    AST_IDLE_SCRATCH_ZERO: assert property (@(posedge clk) disable iff (rst)
        ready |-> (scr == '0)); // R12

endmodule

bind twocnt_bit_stack tcbs_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pri      (pri_q),
    .scr      (scr_q),
    .ready    (ready),
    .done     (done),
    .empty    (empty),
    .overflow (overflow)
);

// File: tb/twocnt_bit_stack_bench.sv
`timescale 1ns/1ps
module twocnt_bit_stack_bench;

    localparam int BW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_pop = 1'b0;
    logic req_bit = 1'b0;
    logic ready, done, pop_bit, empty, overflow;

    int n_checks = 0;
    int n_fail   = 0;
    int mv       = 0;   // bench model of the stored value

    always #2 clk = ~clk;   // 250 MHz

    twocnt_bit_stack #(.CNT_W(BW)) u_twocnt_bit_stack (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_pop   (req_pop),
        .req_bit   (req_bit),
        .ready     (ready),
        .done      (done),
        .pop_bit   (pop_bit),
        .empty     (empty),
        .overflow  (overflow)
    );

    typedef struct packed {
        logic pop;
        logic b;
        logic exp_bit;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 1'b1, 1'b0},  // push 1 -> 1
        '{1'b0, 1'b0, 1'b0},  // push 0 -> 2
        '{1'b0, 1'b1, 1'b0},  // push 1 -> 5
        '{1'b0, 1'b1, 1'b0},  // push 1 -> 11
        '{1'b1, 1'b0, 1'b1},  // pop 1  -> 5
        '{1'b1, 1'b0, 1'b1},  // pop 1  -> 2
        '{1'b0, 1'b0, 1'b0},  // push 0 -> 4
        '{1'b1, 1'b0, 1'b0},  // pop 0  -> 2
        '{1'b1, 1'b0, 1'b0},  // pop 0  -> 1
        '{1'b1, 1'b0, 1'b1},  // pop 1  -> 0
        '{1'b1, 1'b0, 1'b0},  // pop on empty -> 0
        '{1'b0, 1'b0, 1'b0}   // push 0 onto empty stays empty
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Issue one request; stray > 0 raises a second request in that busy cycle
    task automatic run_op(input logic p, input logic b, input int stray, output int lat);
        @(negedge clk);
        req_valid = 1'b1;
        req_pop   = p;
        req_bit   = b;
        @(negedge clk);
        req_valid = 1'b0;
        req_pop   = ~p;
        lat = 0;
        while (!done && lat < 100000) begin
            req_valid = (stray > 0) && (lat == stray);
            @(negedge clk);
            lat++;
        end
        req_valid = 1'b0;
    endtask

    // Run an operation and check it against the bench model
    task automatic model_op(input logic p, input logic b, input int stray, input string tag);
        int lat, exp_lat, exp_bit;
        logic refused, was_empty;
        refused   = !p && (mv >= (1 << (BW - 1)));
        was_empty = p && (mv == 0);
        if (refused || was_empty) begin
            exp_lat = 0;
            exp_bit = 0;
        end else if (p) begin
            exp_lat = 5 * (mv / 2) + (mv % 2) + 3;
            exp_bit = mv % 2;
        end else begin
            exp_lat = 7 * mv + 3 * b + 3;
            exp_bit = 0;
        end
        run_op(p, b, stray, lat);
        chk({tag, " latency (R2/R3/R7/R8)"}, lat, exp_lat);
        if (p) chk({tag, " popped bit R1 R3"}, pop_bit, exp_bit);
        chk({tag, " overflow R8 R9"}, overflow, refused);
        if (!refused) begin
            if (p) mv = mv / 2;
            else   mv = 2 * mv + b;
        end
        @(negedge clk);
        chk({tag, " done pulse ends R5"}, done, 0);
        chk({tag, " ready after done R5"}, ready, 1);
        chk({tag, " empty flag R11"}, empty, (mv == 0));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL R5 watchdog: actual no completion expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        chk("R10 ready", ready, 1);
        chk("R10 done", done, 0);
        chk("R10 empty", empty, 1);
        chk("R10 overflow", overflow, 0);
        chk("R10 pop_bit", pop_bit, 0);

        // Vector table walk: R1 R2 R3 R7 R11
        for (int i = 0; i < NVEC; i++) begin
            model_op(VEC[i].pop, VEC[i].b, 0, $sformatf("vec%0d", i));
            if (VEC[i].pop) chk($sformatf("vec%0d table bit R1", i), pop_bit, VEC[i].exp_bit);
        end

        // R7 pop on empty again, directed
        model_op(1'b1, 1'b0, 0, "R7 empty pop");
        chk("R7 pop bit zero", pop_bit, 0);

        // R6 stray requests while busy are ignored
        model_op(1'b0, 1'b1, 2, "R6 push with stray");
        model_op(1'b0, 1'b1, 5, "R6 second push with stray");
        model_op(1'b1, 1'b0, 3, "R6 pop with stray");
        model_op(1'b1, 1'b0, 0, "R6 follow-up pop");
        chk("R6 stack drained", empty, 1);

        // R8 fill the narrow counter with ones, then refused pushes
        for (int k = 0; k < BW; k++) model_op(1'b0, 1'b1, 0, $sformatf("R8 fill%0d", k));
        chk("R8 model full", mv, (1 << BW) - 1);
        model_op(1'b0, 1'b1, 0, "R8 refused push 1");
        chk("R8 overflow set", overflow, 1);
        model_op(1'b0, 1'b0, 0, "R8 refused push 0");
        // R9 an accepted pop clears overflow; stack was unchanged by refusals
        model_op(1'b1, 1'b0, 0, "R9 pop after refusal");
        chk("R9 overflow cleared", overflow, 0);
        chk("R8 top bit intact", pop_bit, 1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule